// File: doc/BRIEF.md
# Programmable User Sync Generator

This block produces one user-defined timing pulse for a video timing path. Two free-running counters, one for the pixel and one for the line, walk across a field whose size comes from the `total_pix` and `lines_per_field` inputs. When interlace is enabled, a field flag alternates at every field boundary.

Software programs two windows through a small register port. The horizontal window is a pixel range and the vertical window is a line range. A three-bit operator field merges the two windows, with AND taking priority over OR and OR taking priority over XOR. A polarity bit then sets the active level of the output.

Register writes land in a staging copy. The copy that drives the compare logic is reloaded only at the start of a line, so a reprogramming never cuts a pulse short. There is no data stream at the edge of the block, so every pin is a plain control or status signal.

Top module: `usersync_gen`

## Requirements
- R1: The pixel counter steps by one each clock and returns to 0 after the value `total_pix`-1. Each return to 0 advances the line counter.
- R2: The line counter returns to 0 after `lines_per_field`-1. On that wrap the field flag toggles when `interlace` is 1 and is cleared when `interlace` is 0. Flag value 0 is the odd field, and it is the field in use after reset.
- R3: The horizontal window is active while h_start <= pixel < h_stop. Register address 0 holds h_start and address 1 holds h_stop, each 16 bits.
- R4: The vertical window is active while v_start <= line < v_stop, and only in the odd field. Address 2 holds v_start and address 3 holds v_stop, each 15 bits. Bit 15 of these registers is ignored on write and reads back as 0.
- R5: The control register is at address 4. When its bit 2 (AND) is set, the merged signal is H AND V, whatever bits 1 and 0 hold.
- R6: When bit 1 (OR) is set and bit 2 is clear, the merged signal is H OR V, whatever bit 0 holds.
- R7: When only bit 0 (XOR) is set, the merged signal is H XOR V.
- R8: When bits 2..0 are all clear, the merged signal is inactive.
- R9: Control bit 3 selects the polarity. A value of 1 gives an active-low output: the output is the inverse of the merged signal. A value of 0 gives an active-high output. Bit 3 resets to 1 and bits 2..0 reset to 0, so after reset `user_sync` is 1 and address 4 reads 0x0008.
- R10: `user_sync` is registered. It reflects the counters' values and the active configuration of the previous clock cycle.
- R11: A write is visible on `reg_rdata` at once. It first affects `user_sync` on the first pixel of the next line, that is, after the next pixel-counter wrap. Addresses 5 to 7 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| total_pix | input | 16 | Pixels per line |
| lines_per_field | input | 15 | Lines per field |
| interlace | input | 1 | 1 = alternate the field flag at each field end |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data of the staging copy at `reg_addr` |
| user_sync | output | 1 | Final user sync pulse |

## Verification
Assertions check several properties on every cycle. They confirm the pixel counter steps by one and the line counter holds everywhere inside a line. They confirm the active configuration never changes except at a line start. They also check that the registered output matches the AND, OR and no-operator merges of the previous cycle's windows under the previous cycle's polarity.

Some behaviours only the bench scenarios can show. These are the window edge positions, the masking of the vertical window in the even field, XOR behaviour, and the deferral of mid-line writes. The bench shows them by running every operator and polarity combination over whole interlaced and progressive frames against an independent per-cycle model. It also runs directed read-back and reset cases.

// File: rtl/usersync_pkg.sv
package usersync_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_XOR  = 2'd1,
    OP_OR   = 2'd2,
    OP_AND  = 2'd3
  } merge_op_e;

  localparam int CTL_XOR_BIT = 0;
  localparam int CTL_OR_BIT  = 1;
  localparam int CTL_AND_BIT = 2;
  localparam int CTL_POL_BIT = 3;
  localparam int CTL_W       = 4;

  localparam logic [2:0] ADR_H_START = 3'd0;
  localparam logic [2:0] ADR_H_STOP  = 3'd1;
  localparam logic [2:0] ADR_V_START = 3'd2;
  localparam logic [2:0] ADR_V_STOP  = 3'd3;
  localparam logic [2:0] ADR_CTRL    = 3'd4;

  // Priority: AND over OR over XOR (R5, R6, R7)
  function automatic merge_op_e decode_op(input logic [2:0] ops);
    if (ops[CTL_AND_BIT])      return OP_AND;
    else if (ops[CTL_OR_BIT])  return OP_OR;
    else if (ops[CTL_XOR_BIT]) return OP_XOR;
    else                       return OP_NONE;
  endfunction

  function automatic logic merge(input merge_op_e op, input logic h, input logic v);
    case (op)
      OP_AND:  return h & v;
      OP_OR:   return h | v;
      OP_XOR:  return h ^ v;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/usersync_timebase.sv
module usersync_timebase #(
  parameter int PIX_W  = 16,
  parameter int LINE_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PIX_W-1:0]  total_pix,
  input  logic [LINE_W-1:0] lines_per_field,
  input  logic              interlace,
  output logic [PIX_W-1:0]  pix_cnt,
  output logic [LINE_W-1:0] line_cnt,
  output logic              even_field,
  output logic              line_start
);
  logic [PIX_W:0]  pix_inc;
  logic [LINE_W:0] line_inc;
  logic            line_wrap;

  assign pix_inc    = {1'b0, pix_cnt} + 1'b1;
  assign line_inc   = {1'b0, line_cnt} + 1'b1;
  assign line_start = (pix_inc >= {1'b0, total_pix});
  assign line_wrap  = (line_inc >= {1'b0, lines_per_field});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_cnt    <= '0;
      line_cnt   <= '0;
      even_field <= 1'b0;
    end else if (line_start) begin
      pix_cnt <= '0;
      if (line_wrap) begin
        line_cnt   <= '0;
        even_field <= interlace & ~even_field;
      end else begin
        line_cnt <= line_inc[LINE_W-1:0];
      end
    end else begin
      pix_cnt <= pix_inc[PIX_W-1:0];
    end
  end
endmodule

// File: rtl/usersync_regs.sv
module usersync_regs
  import usersync_pkg::*;
#(
  parameter int PIX_W  = 16,
  parameter int LINE_W = 15,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              load,
  output logic [PIX_W-1:0]  act_h_start,
  output logic [PIX_W-1:0]  act_h_stop,
  output logic [LINE_W-1:0] act_v_start,
  output logic [LINE_W-1:0] act_v_stop,
  output logic [CTL_W-1:0]  act_ctrl
);
  localparam logic [CTL_W-1:0] CTRL_RST = CTL_W'(1) << CTL_POL_BIT;

  logic [PIX_W-1:0]  st_h_start, st_h_stop;
  logic [LINE_W-1:0] st_v_start, st_v_stop;
  logic [CTL_W-1:0]  st_ctrl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_h_start <= '0;
      st_h_stop  <= '0;
      st_v_start <= '0;
      st_v_stop  <= '0;
      st_ctrl    <= CTRL_RST;
    end else if (we) begin
      case (3'(addr))
        ADR_H_START: st_h_start <= wdata[PIX_W-1:0];
        ADR_H_STOP:  st_h_stop  <= wdata[PIX_W-1:0];
        ADR_V_START: st_v_start <= wdata[LINE_W-1:0];
        ADR_V_STOP:  st_v_stop  <= wdata[LINE_W-1:0];
        ADR_CTRL:    st_ctrl    <= wdata[CTL_W-1:0];
        default: ;
      endcase
    end
  end

  // Active copy reloads only at a line start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_h_start <= '0;
      act_h_stop  <= '0;
      act_v_start <= '0;
      act_v_stop  <= '0;
      act_ctrl    <= CTRL_RST;
    end else if (load) begin
      act_h_start <= st_h_start;
      act_h_stop  <= st_h_stop;
      act_v_start <= st_v_start;
      act_v_stop  <= st_v_stop;
      act_ctrl    <= st_ctrl;
    end
  end

  always_comb begin
    rdata = '0;
    case (3'(addr))
      ADR_H_START: rdata = DATA_W'(st_h_start);
      ADR_H_STOP:  rdata = DATA_W'(st_h_stop);
      ADR_V_START: rdata = DATA_W'(st_v_start);
      ADR_V_STOP:  rdata = DATA_W'(st_v_stop);
      ADR_CTRL:    rdata = DATA_W'(st_ctrl);
      default:     rdata = '0;
    endcase
  end
endmodule

// File: rtl/usersync_window.sv
module usersync_window
  import usersync_pkg::*;
#(
  parameter int PIX_W  = 16,
  parameter int LINE_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PIX_W-1:0]  pix_cnt,
  input  logic [LINE_W-1:0] line_cnt,
  input  logic              even_field,
  input  logic [PIX_W-1:0]  h_start,
  input  logic [PIX_W-1:0]  h_stop,
  input  logic [LINE_W-1:0] v_start,
  input  logic [LINE_W-1:0] v_stop,
  input  logic [CTL_W-1:0]  ctrl,
  output logic              h_act,
  output logic              v_act,
  output logic              sync_out
);
  merge_op_e op;
  logic      merged;

  assign h_act  = (pix_cnt >= h_start) && (pix_cnt < h_stop);
  assign v_act  = (line_cnt >= v_start) && (line_cnt < v_stop) && !even_field;
  assign op     = decode_op(ctrl[CTL_AND_BIT:CTL_XOR_BIT]);
  assign merged = merge(op, h_act, v_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_out <= 1'b1;
    else        sync_out <= merged ^ ctrl[CTL_POL_BIT];
  end
endmodule

// File: rtl/usersync_gen.sv
module usersync_gen
  import usersync_pkg::*;
#(
  parameter int PIX_W  = 16,
  parameter int LINE_W = 15,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PIX_W-1:0]  total_pix,
  input  logic [LINE_W-1:0] lines_per_field,
  input  logic              interlace,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              user_sync
);
  logic [PIX_W-1:0]  pix_cnt;
  logic [LINE_W-1:0] line_cnt;
  logic              even_field, line_start;
  logic [PIX_W-1:0]  act_h_start, act_h_stop;
  logic [LINE_W-1:0] act_v_start, act_v_stop;
  logic [CTL_W-1:0]  act_ctrl;
  logic              h_act, v_act;

  usersync_timebase #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .total_pix(total_pix),
    .lines_per_field(lines_per_field), .interlace(interlace),
    .pix_cnt(pix_cnt), .line_cnt(line_cnt), .even_field(even_field),
    .line_start(line_start)
  );

  usersync_regs #(.PIX_W(PIX_W), .LINE_W(LINE_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .load(line_start),
    .act_h_start(act_h_start), .act_h_stop(act_h_stop),
    .act_v_start(act_v_start), .act_v_stop(act_v_stop), .act_ctrl(act_ctrl)
  );

  usersync_window #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_win (
    .clk(clk), .rst_n(rst_n), .pix_cnt(pix_cnt), .line_cnt(line_cnt),
    .even_field(even_field), .h_start(act_h_start), .h_stop(act_h_stop),
    .v_start(act_v_start), .v_stop(act_v_stop), .ctrl(act_ctrl),
    .h_act(h_act), .v_act(v_act), .sync_out(user_sync)
  );
endmodule

// File: rtl/usersync_gen_chk.sv
module usersync_gen_chk #(
  parameter int PIX_W  = 16,
  parameter int LINE_W = 15,
  parameter int CTL_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [PIX_W-1:0]  px,
  input logic [LINE_W-1:0] line,
  input logic [PIX_W-1:0]  hs,
  input logic [PIX_W-1:0]  he,
  input logic [LINE_W-1:0] vs,
  input logic [LINE_W-1:0] ve,
  input logic [CTL_W-1:0]  ctl,
  input logic              h_act,
  input logic              v_act,
  input logic              user_sync
);
  // R1: inside a line the pixel counter steps by one
  p_pix_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (px != '0) |-> (px == PIX_W'($past(px) + 1'b1)));

  // R2: the line counter only moves at a pixel wrap
  p_line_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (px != '0) |-> $stable(line));

  // R11: the active configuration changes only at a line start
  p_cfg_defer_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (px != '0) |-> $stable({hs, he, vs, ve, ctl}));

  // R5, R9, R10: AND merge, registered one cycle later
  p_and_merge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctl[2]) |-> (user_sync == ($past(ctl[3]) ^ ($past(h_act) & $past(v_act)))));

  // R6: OR merge when AND is clear
  p_or_merge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctl[2:1]) == 2'b01) |-> (user_sync == ($past(ctl[3]) ^ ($past(h_act) | $past(v_act)))));

  // R8: no operator holds the inactive level
  p_none_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctl[2:0]) == 3'b000) |-> (user_sync == $past(ctl[3])));
endmodule

bind usersync_gen usersync_gen_chk #(.PIX_W(PIX_W), .LINE_W(LINE_W), .CTL_W(4)) u_chk (
  .clk(clk), .rst_n(rst_n), .px(pix_cnt), .line(line_cnt),
  .hs(act_h_start), .he(act_h_stop), .vs(act_v_start), .ve(act_v_stop),
  .ctl(act_ctrl), .h_act(h_act), .v_act(v_act), .user_sync(user_sync)
);

// File: tb/usersync_gen_tb.sv
`timescale 1ns/1ps
module usersync_gen_tb;
  localparam int NPIX = 12;
  localparam int NLIN = 6;
  localparam int NVEC = 9;
  localparam int RUN  = 160;

  // {h_start, h_stop, v_start, v_stop, ctrl}
  localparam logic [79:0] VEC [NVEC] = '{
    {16'd2, 16'd7,  16'd1, 16'd4, 16'h000C},  // R5 R9 AND, active low
    {16'd0, 16'd12, 16'd2, 16'd5, 16'h0004},  // R5 R3 AND, active high, full line
    {16'd3, 16'd9,  16'd1, 16'd3, 16'h0002},  // R6 OR, active high
    {16'd1, 16'd5,  16'd0, 16'd2, 16'h0001},  // R7 XOR, active high
    {16'd4, 16'd10, 16'd3, 16'd6, 16'h0009},  // R7 XOR, active low
    {16'd2, 16'd6,  16'd2, 16'd4, 16'h0007},  // R5 AND wins over OR and XOR
    {16'd5, 16'd8,  16'd0, 16'd3, 16'h0003},  // R6 OR wins over XOR
    {16'd2, 16'd7,  16'd1, 16'd4, 16'h0008},  // R8 no operator, active low
    {16'd0, 16'd12, 16'd0, 16'd6, 16'h0000}   // R8 no operator, active high
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] total_pix = 16'(NPIX);
  logic [14:0] lines_per_field = 15'(NLIN);
  logic        interlace = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        user_sync;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int vec_id = -1;

  always #10 clk = ~clk;

  usersync_gen u_dut (
    .clk(clk), .rst_n(rst_n), .total_pix(total_pix), .lines_per_field(lines_per_field),
    .interlace(interlace), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .user_sync(user_sync)
  );

  // Independent reference built from R1..R11
  int   m_px, m_ln;
  bit   m_even;
  int   s_hs, s_he, s_vs, s_ve, a_hs, a_he, a_vs, a_ve;
  logic [3:0] s_ctl, a_ctl;
  logic exp_out;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_px <= 0; m_ln <= 0; m_even <= 0;
      s_hs <= 0; s_he <= 0; s_vs <= 0; s_ve <= 0; s_ctl <= 4'h8;
      a_hs <= 0; a_he <= 0; a_vs <= 0; a_ve <= 0; a_ctl <= 4'h8;
      exp_out <= 1'b1;
    end else begin
      bit h, v, c;
      h = (m_px >= a_hs) && (m_px < a_he);
      v = (m_ln >= a_vs) && (m_ln < a_ve) && !m_even;
      if (a_ctl[2])      c = h & v;
      else if (a_ctl[1]) c = h | v;
      else if (a_ctl[0]) c = h ^ v;
      else               c = 1'b0;
      exp_out <= a_ctl[3] ? ~c : c;
      if (m_px + 1 >= int'(total_pix)) begin
        m_px <= 0;
        a_hs <= s_hs; a_he <= s_he; a_vs <= s_vs; a_ve <= s_ve; a_ctl <= s_ctl;
        if (m_ln + 1 >= int'(lines_per_field)) begin
          m_ln <= 0;
          m_even <= interlace ? ~m_even : 1'b0;
        end else m_ln <= m_ln + 1;
      end else m_px <= m_px + 1;
      if (reg_we) begin
        case (reg_addr)
          3'd0: s_hs <= int'(reg_wdata);
          3'd1: s_he <= int'(reg_wdata);
          3'd2: s_vs <= int'(reg_wdata[14:0]);
          3'd3: s_ve <= int'(reg_wdata[14:0]);
          3'd4: s_ctl <= reg_wdata[3:0];
          default: ;
        endcase
      end
    end
  end

  // Per-cycle stream compare: R1 R2 R3 R4 counters and windows, R10 latency, R11 deferral
  always @(negedge clk) begin
    if (rst_n && vec_id >= 0) begin
      checks++;
      if (user_sync !== exp_out) begin
        fails++;
        $display("FAIL R10 R11 stream vec %0d px %0d line %0d: user_sync=%b expected %b",
                 vec_id, m_px, m_ln, user_sync, exp_out);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic chk_rd(input logic [2:0] a, input logic [15:0] exp, input string req);
    @(negedge clk);
    reg_addr = a;
    #1;
    checks++;
    if (reg_rdata !== exp) begin
      fails++;
      $display("FAIL %s read addr %0d: rdata=%h expected %h", req, a, reg_rdata, exp);
    end
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    checks++;
    if (user_sync !== 1'b1) begin
      fails++; $display("FAIL R9 reset output: %b expected 1", user_sync);
    end
    rst_n = 1'b1;
    chk_rd(3'd4, 16'h0008, "R9");
    chk_rd(3'd0, 16'h0000, "R3");

    // Vector table: write mid-line, then run whole frames
    for (int i = 0; i < NVEC; i++) begin
      vec_id = i;
      interlace = i[0];
      wr(3'd0, VEC[i][79:64]);
      wr(3'd1, VEC[i][63:48]);
      wr(3'd2, VEC[i][47:32]);
      wr(3'd3, VEC[i][31:16]);
      wr(3'd4, VEC[i][15:0]);
      repeat (RUN) @(negedge clk);
    end

    // R4: bit 15 of the line registers is dropped
    wr(3'd2, 16'hFFFF);
    chk_rd(3'd2, 16'h7FFF, "R4");
    wr(3'd3, 16'h8003);
    chk_rd(3'd3, 16'h0003, "R4");
    // R11: immediate read-back, unmapped addresses read 0
    wr(3'd0, 16'h0005);
    chk_rd(3'd0, 16'h0005, "R11");
    wr(3'd6, 16'hABCD);
    chk_rd(3'd6, 16'h0000, "R11");
    chk_rd(3'd4, 16'h0000, "R11");
    // R11: the unmapped write left the other registers unchanged
    chk_rd(3'd1, 16'h000C, "R11");
    repeat (2 * NPIX * NLIN) @(negedge clk);

    // R9: a second reset restores active-low idle
    rst_n = 1'b0;
    vec_id = -1;
    @(negedge clk);
    checks++;
    if (user_sync !== 1'b1) begin
      fails++; $display("FAIL R9 re-reset output: %b expected 1", user_sync);
    end
    chk_rd(3'd4, 16'h0008, "R9");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule